// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the SCL waveform and the bus-condition timing of an I2C master from a reference clock. The bit engine issues one command at a time: START, one data bit, repeated START or STOP. For each command the block runs a fixed sequence of timed phases and returns single-cycle strobes. The strobes say when SDA may change, when SDA is to be sampled, and when SCL rises or falls. It also drives the SCL level.

A prescaler divides the reference clock by its programmed value plus one. Every phase length is counted in those prescaled ticks. After SCL is released there is one exception: a fixed synchronisation overhead plus a glitch-filter term, counted in reference cycles. A full bit period is therefore (div+1)·(low+high+2) plus that overhead.

Two timing sets exist, one for fast mode and one for high-speed mode, and a mode input picks between them. The data-hold word is common to both sets. The selected set is captured when a command is accepted, so the inputs may change while a command runs.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `scl_o` is 1, `bus_free_o` is 1, `busy_o` is 0, `cmd_ready_o` is 1 and every strobe is 0.
- R2: A phase programmed with field value F lasts (F+1)·(D+1) reference cycles, where D is the prescaler field, taken from bits 23:16 of timing word 3.
- R3: A data-bit command (code 1) works as follows:
  - SDA may change (`sda_chg_o`) once data hold has elapsed after the command is accepted. Data hold is bits 7:0 of the hold word.
  - SCL then stays low for a further max(setup, low−hold−1) phase. Setup is word 2 bits 31:24 and low is word 2 bits 15:8. SCL then rises.
  - After the overhead, SCL stays high for a phase of word 2 bits 7:0.
  - `sda_smp_o`, `scl_fall_o` and `done_o` then pulse together, and SCL ends low.
- R4: The overhead after each SCL release lasts OVH_BASE + FILTER_PASSES·filt reference cycles, which is 8 + 2·filt by default. filt is the 3-bit `filt_i`.
- R5: A START (code 0) is legal only while the bus is free:
  - SDA changes after a phase of word 1 bits 31:24 (START setup).
  - SCL then falls after a phase of word 1 bits 23:16 (START hold).
  - `done_o` pulses, and the bus is then held.
- R6: A STOP (code 3) proceeds as follows:
  - It runs the data-bit low interval: SDA changes after hold, and SCL rises after the further setup phase.
  - After the overhead it waits a phase of word 1 bits 15:8 (STOP setup).
  - It then pulses `sda_chg_o` and `done_o` together.
  - SCL stays high and `bus_free_o` returns to 1.
- R7: A repeated START (code 2) proceeds as follows:
  - SDA changes after data hold.
  - SCL rises after a release phase of word 3 bits 7:0.
  - After the overhead, it runs the START setup and START hold phases of R5 and ends with SCL low.
- R8: With `hs_sel_i`=1 the high-speed words set every phase length; with `hs_sel_i`=0 the fast-mode words do. Data hold and filt are shared by both sets.
- R9: Timing words, `hs_sel_i` and `filt_i` are sampled only when a command is accepted. Changing them while a command runs does not alter that command's timing.
- R10: A command that does not fit the bus state is ignored: no strobe, no `busy_o`, no change of SCL. This covers START while the bus is held, and bit, repeated START or STOP while the bus is free.
- R11: `scl_rise_o` and `scl_fall_o` pulse exactly in the cycles where `scl_o` rises or falls. `sda_chg_o`, `scl_rise_o` and `scl_fall_o` never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hs_sel_i | input | 1 | 1 selects the high-speed timing set |
| filt_i | input | 3 | Glitch-filter cycle count |
| fs_word1_i | input | 32 | Fast set: START setup, START hold, STOP setup |
| fs_word2_i | input | 32 | Fast set: data setup, SCL low, SCL high |
| fs_word3_i | input | 32 | Fast set: prescaler, repeated-start release |
| hs_word1_i | input | 32 | High-speed set, same layout as fs_word1_i |
| hs_word2_i | input | 32 | High-speed set, same layout as fs_word2_i |
| hs_word3_i | input | 32 | High-speed set, same layout as fs_word3_i |
| hold_word_i | input | 32 | Data hold in bits 7:0 |
| cmd_valid_i | input | 1 | Command request |
| cmd_i | input | 2 | 0 START, 1 bit, 2 repeated START, 3 STOP |
| cmd_ready_o | output | 1 | Block idle; a request is taken this cycle |
| busy_o | output | 1 | Command in progress |
| bus_free_o | output | 1 | No START outstanding |
| scl_o | output | 1 | SCL level (1 = released) |
| scl_rise_o | output | 1 | Pulse: SCL released |
| scl_fall_o | output | 1 | Pulse: SCL pulled low |
| sda_chg_o | output | 1 | Pulse: SDA may change now |
| sda_smp_o | output | 1 | Pulse: sample SDA now |
| done_o | output | 1 | Pulse: command finished |

## Verification
The assertions check, on every cycle, several invariants:
- SCL edges and their strobes agree.
- The edge and change strobes are mutually exclusive.
- Sampling only happens at the end of an SCL high interval.
- A free bus always shows SCL high.
- Nothing pulses while the block is idle outside a completion.

Only the bench's scenarios can show the exact cycle at which each strobe lands. This covers the product of prescaler and field, the max rule of the low interval, the filter overhead, the choice of timing set, and capture at acceptance. The bench makes those checks by comparing whole command traces against computed event times.

// File: rtl/sclt_pkg.sv
package sclt_pkg;
   localparam int FW     = 8;   // width of every timing field
   localparam int OVW    = 6;   // width of the overhead count
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      CMD_START  = 2'd0,
      CMD_BIT    = 2'd1,
      CMD_RSTART = 2'd2,
      CMD_STOP   = 2'd3
   } cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_HOLD, ST_SETUP, ST_RSREL, ST_RISE,
      ST_HIGH, ST_STASU, ST_STAHD, ST_STOSU
   } phase_e;

   typedef struct packed {
      logic [FW-1:0]  su_sta;
      logic [FW-1:0]  hd_sta;
      logic [FW-1:0]  su_sto;
      logic [FW-1:0]  low_rest;
      logic [FW-1:0]  high;
      logic [FW-1:0]  div;
      logic [FW-1:0]  sr_rel;
      logic [FW-1:0]  hd_dat;
      logic [OVW-1:0] ovh;
   } tcfg_t;
endpackage

// File: rtl/sclt_cfg_sel.sv
module sclt_cfg_sel
   import sclt_pkg::*;
#(
   parameter int FILTER_PASSES = 2,
   parameter int OVH_BASE      = 8
) (
   input  logic              hs_sel_i,
   input  logic [2:0]        filt_i,
   input  logic [WORD_W-1:0] fs_w1_i,
   input  logic [WORD_W-1:0] fs_w2_i,
   input  logic [WORD_W-1:0] fs_w3_i,
   input  logic [WORD_W-1:0] hs_w1_i,
   input  logic [WORD_W-1:0] hs_w2_i,
   input  logic [WORD_W-1:0] hs_w3_i,
   input  logic [WORD_W-1:0] hold_w_i,
   output tcfg_t             cfg_o
);
   localparam int MAX_OVH = OVH_BASE + FILTER_PASSES * 7;

   logic [WORD_W-1:0] w1, w2, w3;
   logic [FW-1:0]     t_low, t_su_dat;
   logic [FW:0]       rest_diff;
   logic [OVW-1:0]    flt_term;

   assign w1 = hs_sel_i ? hs_w1_i : fs_w1_i;
   assign w2 = hs_sel_i ? hs_w2_i : fs_w2_i;
   assign w3 = hs_sel_i ? hs_w3_i : fs_w3_i;

   assign t_low     = w2[15:8];
   assign t_su_dat  = w2[31:24];
   assign rest_diff = {1'b0, t_low} - {1'b0, hold_w_i[7:0]} - 9'd1;

   generate
      if (OVH_BASE < 1 || MAX_OVH >= (1 << OVW)) begin : g_bad_ovh
         $error("sclt_cfg_sel: OVH_BASE out of range");
      end
      if (FILTER_PASSES == 2) begin : g_filt_twice
         assign flt_term = {2'b00, filt_i, 1'b0};
      end else if (FILTER_PASSES == 1) begin : g_filt_once
         assign flt_term = {3'b000, filt_i};
      end else begin : g_filt_bad
         $error("sclt_cfg_sel: FILTER_PASSES must be 1 or 2");
         assign flt_term = '0;
      end
   endgenerate

   always_comb begin
      cfg_o.su_sta   = w1[31:24];
      cfg_o.hd_sta   = w1[23:16];
      cfg_o.su_sto   = w1[15:8];
      cfg_o.high     = w2[7:0];
      cfg_o.div      = w3[23:16];
      cfg_o.sr_rel   = w3[7:0];
      cfg_o.hd_dat   = hold_w_i[7:0];
      cfg_o.ovh      = OVW'(OVH_BASE) + flt_term;
      // rest of the low interval: at least data setup, else what low still needs
      if (!rest_diff[FW] && (rest_diff[FW-1:0] > t_su_dat))
         cfg_o.low_rest = rest_diff[FW-1:0];
      else
         cfg_o.low_rest = t_su_dat;
   end

   logic unused_bits;
   assign unused_bits = ^{w1[7:0], w2[23:16], w3[31:24], w3[15:8], hold_w_i[31:8]};
endmodule

// File: rtl/sclt_prescaler.sv
module sclt_prescaler #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         restart_i,
   input  logic [W-1:0] div_i,
   output logic         tick_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("sclt_prescaler: W must be positive");
      end
   endgenerate

   logic [W-1:0] cnt;

   assign tick_o = (cnt == div_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cnt <= '0;
      else if (restart_i || tick_o) cnt <= '0;
      else                          cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
   import sclt_pkg::*;
#(
   parameter int FILTER_PASSES = 2,
   parameter int OVH_BASE      = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              hs_sel_i,
   input  logic [2:0]        filt_i,
   input  logic [WORD_W-1:0] fs_word1_i,
   input  logic [WORD_W-1:0] fs_word2_i,
   input  logic [WORD_W-1:0] fs_word3_i,
   input  logic [WORD_W-1:0] hs_word1_i,
   input  logic [WORD_W-1:0] hs_word2_i,
   input  logic [WORD_W-1:0] hs_word3_i,
   input  logic [WORD_W-1:0] hold_word_i,
   input  logic              cmd_valid_i,
   input  logic [1:0]        cmd_i,
   output logic              cmd_ready_o,
   output logic              busy_o,
   output logic              bus_free_o,
   output logic              scl_o,
   output logic              scl_rise_o,
   output logic              scl_fall_o,
   output logic              sda_chg_o,
   output logic              sda_smp_o,
   output logic              done_o
);
   tcfg_t          cfg_live, cfg_q, cfg_use;
   phase_e         state, nxt_state;
   cmd_e           cur_cmd, nxt_cmd;
   logic [FW-1:0]  ph_cnt, nxt_cnt;
   logic           tick, restart, latch, phase_end, legal;
   logic           scl_q, nxt_scl, free_q, nxt_free;
   logic           n_rise, n_fall, n_chg, n_smp, n_done;

   sclt_cfg_sel #(.FILTER_PASSES(FILTER_PASSES), .OVH_BASE(OVH_BASE)) u_sel (
      .hs_sel_i(hs_sel_i), .filt_i(filt_i),
      .fs_w1_i(fs_word1_i), .fs_w2_i(fs_word2_i), .fs_w3_i(fs_word3_i),
      .hs_w1_i(hs_word1_i), .hs_w2_i(hs_word2_i), .hs_w3_i(hs_word3_i),
      .hold_w_i(hold_word_i), .cfg_o(cfg_live)
   );

   // live values while idle (accept cycle), captured copy while running
   assign cfg_use = (state == ST_IDLE) ? cfg_live : cfg_q;

   sclt_prescaler #(.W(FW)) u_pre (
      .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart),
      .div_i(cfg_use.div), .tick_o(tick)
   );

   assign legal     = ((cmd_e'(cmd_i) == CMD_START) == free_q);
   assign phase_end = (state == ST_RISE) ? (ph_cnt == '0) : (tick && (ph_cnt == '0));

   always_comb begin
      nxt_state = state;
      nxt_cmd   = cur_cmd;
      nxt_cnt   = ph_cnt;
      nxt_scl   = scl_q;
      nxt_free  = free_q;
      restart   = 1'b0;
      latch     = 1'b0;
      {n_rise, n_fall, n_chg, n_smp, n_done} = '0;
      if (state == ST_IDLE) begin
         if (cmd_valid_i && legal) begin
            latch   = 1'b1;
            restart = 1'b1;
            nxt_cmd = cmd_e'(cmd_i);
            if (cmd_e'(cmd_i) == CMD_START) begin
               nxt_state = ST_STASU;
               nxt_cnt   = cfg_use.su_sta;
            end else begin
               nxt_state = ST_HOLD;
               nxt_cnt   = cfg_use.hd_dat;
            end
         end
      end else if (phase_end) begin
         restart = 1'b1;
         unique case (state)
            ST_HOLD: begin
               n_chg = 1'b1;
               if (cur_cmd == CMD_RSTART) begin
                  nxt_state = ST_RSREL;
                  nxt_cnt   = cfg_use.sr_rel;
               end else begin
                  nxt_state = ST_SETUP;
                  nxt_cnt   = cfg_use.low_rest;
               end
            end
            ST_SETUP, ST_RSREL: begin
               n_rise    = 1'b1;
               nxt_scl   = 1'b1;
               nxt_state = ST_RISE;
               nxt_cnt   = FW'(cfg_use.ovh) - 1'b1;
            end
            ST_RISE: begin
               if (cur_cmd == CMD_BIT) begin
                  nxt_state = ST_HIGH;
                  nxt_cnt   = cfg_use.high;
               end else if (cur_cmd == CMD_RSTART) begin
                  nxt_state = ST_STASU;
                  nxt_cnt   = cfg_use.su_sta;
               end else begin
                  nxt_state = ST_STOSU;
                  nxt_cnt   = cfg_use.su_sto;
               end
            end
            ST_HIGH: begin
               {n_smp, n_fall, n_done} = '1;
               nxt_scl   = 1'b0;
               nxt_state = ST_IDLE;
            end
            ST_STASU: begin
               n_chg     = 1'b1;
               nxt_state = ST_STAHD;
               nxt_cnt   = cfg_use.hd_sta;
            end
            ST_STAHD: begin
               {n_fall, n_done} = '1;
               nxt_scl   = 1'b0;
               nxt_free  = 1'b0;
               nxt_state = ST_IDLE;
            end
            ST_STOSU: begin
               {n_chg, n_done} = '1;
               nxt_free  = 1'b1;
               nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
         endcase
      end else if (state == ST_RISE || tick) begin
         nxt_cnt = ph_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state   <= ST_IDLE;
         cur_cmd <= CMD_START;
         ph_cnt  <= '0;
         cfg_q   <= '0;
         scl_q   <= 1'b1;
         free_q  <= 1'b1;
         {scl_rise_o, scl_fall_o, sda_chg_o, sda_smp_o, done_o} <= '0;
      end else begin
         state   <= nxt_state;
         cur_cmd <= nxt_cmd;
         ph_cnt  <= nxt_cnt;
         if (latch) cfg_q <= cfg_live;
         scl_q   <= nxt_scl;
         free_q  <= nxt_free;
         {scl_rise_o, scl_fall_o, sda_chg_o, sda_smp_o, done_o} <=
            {n_rise, n_fall, n_chg, n_smp, n_done};
      end
   end

   assign scl_o       = scl_q;
   assign bus_free_o  = free_q;
   assign busy_o      = (state != ST_IDLE);
   assign cmd_ready_o = (state == ST_IDLE);

   AST_RISE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(scl_o) |-> scl_rise_o); // R11
   AST_FALL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(scl_o) |-> scl_fall_o); // R11
   AST_EDGE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({sda_chg_o, scl_rise_o, scl_fall_o})); // R11
   AST_SMP_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sda_smp_o |-> ($past(scl_o) && scl_fall_o && done_o)); // R3
   AST_FREE_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_free_o |-> scl_o); // R6
   AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !done_o) |-> !(sda_chg_o || sda_smp_o || scl_rise_o || scl_fall_o)); // R10
   AST_ILLEGAL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_ready_o && cmd_valid_i && !legal) |=> (!busy_o && $stable(scl_o))); // R10
endmodule

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        hs_sel = 1'b0;
   logic [2:0]  filt = '0;
   logic [31:0] fs1 = '0, fs2 = '0, fs3 = '0, hs1 = '0, hs2 = '0, hs3 = '0, hold = '0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd = '0;
   logic        cmd_ready, busy, bus_free, scl, s_rise, s_fall, s_chg, s_smp, done;

   int vectors = 0, miscompares = 0;
   int mx_f = 7, mx_d = 3;
   bit exp_free = 1'b1, exp_scl = 1'b1;

   always #(CLK_PERIOD / 2) clk = ~clk;

   scl_timing_gen u0 (
      .clk_i(clk), .rst_ni(rst_n), .hs_sel_i(hs_sel), .filt_i(filt),
      .fs_word1_i(fs1), .fs_word2_i(fs2), .fs_word3_i(fs3),
      .hs_word1_i(hs1), .hs_word2_i(hs2), .hs_word3_i(hs3),
      .hold_word_i(hold), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
      .cmd_ready_o(cmd_ready), .busy_o(busy), .bus_free_o(bus_free), .scl_o(scl),
      .scl_rise_o(s_rise), .scl_fall_o(s_fall), .sda_chg_o(s_chg),
      .sda_smp_o(s_smp), .done_o(done)
   );

   function automatic int ph(int f, int d);
      return (f + 1) * (d + 1);
   endfunction

   function automatic logic [7:0] rf(int mx);
      return 8'($urandom_range(mx, 0));
   endfunction

   // word layout: w1 = {su_sta, hd_sta, su_sto, junk}, w2 = {su_dat, junk, low, high},
   // w3 = {junk, div, junk, sr_rel}; hold = {junk, hd_dat}
   task automatic set_set(input bit hs, input int su_sta, hd_sta, su_sto, su_dat, low, high, div, sr);
      logic [31:0] a, b, c;
      a = {8'(su_sta), 8'(hd_sta), 8'(su_sto), rf(255)};
      b = {8'(su_dat), rf(255), 8'(low), 8'(high)};
      c = {rf(255), 8'(div), rf(255), 8'(sr)};
      if (hs) begin hs1 = a; hs2 = b; hs3 = c; end
      else    begin fs1 = a; fs2 = b; fs3 = c; end
   endtask

   task automatic scramble();
      for (int s = 0; s < 2; s++)
         set_set(s[0], rf(mx_f), rf(mx_f), rf(mx_f), rf(mx_f), rf(mx_f), rf(mx_f), rf(mx_d), rf(mx_f));
      hold   = {rf(255), rf(255), rf(255), rf(mx_f)};
      filt   = 3'($urandom_range(7, 0));
      hs_sel = 1'($urandom_range(1, 0));
   endtask

   task automatic report(input bit bad, input string req, input string msg);
      vectors++;
      if (bad) begin
         miscompares++;
         $display("FAIL %s %s", req, msg);
      end
   endtask

   task automatic run_cmd(input logic [1:0] c);
      logic [31:0] w1, w2, w3;
      int d, thd, ls, ovh, ca, cb, rs, fl, sm, dn, n;
      bit legal, bad;
      string req, msg;
      w1 = hs_sel ? hs1 : fs1;   // R8: set picked by hs_sel
      w2 = hs_sel ? hs2 : fs2;
      w3 = hs_sel ? hs3 : fs3;
      d   = int'(w3[23:16]);
      thd = int'(hold[7:0]);
      ls  = int'(w2[15:8]) - thd - 1;
      if (ls <= int'(w2[31:24])) ls = int'(w2[31:24]);
      ovh = 8 + 2 * int'(filt);          // R4
      ca = -1; cb = -1; rs = -1; fl = -1; sm = -1;
      case (c)
         2'd0: begin req = "R5"; ca = ph(w1[31:24], d); fl = ca + ph(w1[23:16], d); dn = fl; end
         2'd1: begin req = "R3"; ca = ph(thd, d); rs = ca + ph(ls, d);
                     fl = rs + ovh + ph(w2[7:0], d); sm = fl; dn = fl; end
         2'd2: begin req = "R7"; ca = ph(thd, d); rs = ca + ph(w3[7:0], d);
                     cb = rs + ovh + ph(w1[31:24], d); fl = cb + ph(w1[23:16], d); dn = fl; end
         default: begin req = "R6"; ca = ph(thd, d); rs = ca + ph(ls, d);
                     cb = rs + ovh + ph(w1[15:8], d); dn = cb; end
      endcase
      legal = ((c == 2'd0) == exp_free);
      @(negedge clk);
      cmd = c; cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      scramble();                        // R9: inputs change after acceptance
      bad = 1'b0; msg = "";
      if (!legal) begin                  // R10
         for (int k = 0; k < 12; k++) begin
            if (!bad && (busy || !cmd_ready || scl !== exp_scl ||
                         {s_chg, s_rise, s_fall, s_smp, done} != 5'b0)) begin
               bad = 1'b1;
               msg = $sformatf("ignored cmd %0d: busy=%b scl=%b strobes=%b expected busy=0 scl=%b strobes=00000",
                               c, busy, scl, {s_chg, s_rise, s_fall, s_smp, done}, exp_scl);
            end
            @(negedge clk);
         end
         report(bad, "R10", msg);
         return;
      end
      n = 0;
      while (n < dn && n < 100000) begin
         logic [5:0] got, exp;
         @(posedge clk); n++;
         @(negedge clk);
         got = {s_chg, s_rise, s_fall, s_smp, done, busy};
         exp = {(n == ca) || (n == cb), n == rs, n == fl, n == sm, n == dn, n < dn};
         if (!bad && got != exp) begin
            bad = 1'b1;
            msg = $sformatf("cmd %0d cycle %0d chg/rise/fall/smp/done/busy got %b expected %b (R2 R4 R8 R9)",
                            c, n, got, exp);
         end
      end
      if (c == 2'd0) exp_free = 1'b0;
      if (c == 2'd3) exp_free = 1'b1;
      exp_scl = (c == 2'd3);
      if (!bad && (scl !== exp_scl || bus_free !== exp_free)) begin
         bad = 1'b1;
         msg = $sformatf("end state scl=%b free=%b expected scl=%b free=%b", scl, bus_free, exp_scl, exp_free);
      end
      report(bad, req, msg);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete, got timeout expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5C1_7A9));
      repeat (3) @(negedge clk);
      // R1: reset state
      report(!(scl === 1'b1 && bus_free === 1'b1 && busy === 1'b0 && cmd_ready === 1'b1 &&
               {s_chg, s_rise, s_fall, s_smp, done} == 5'b0), "R1",
             $sformatf("in reset scl/free/busy/ready=%b%b%b%b expected 1101", scl, bus_free, busy, cmd_ready));
      rst_n = 1'b1;
      @(negedge clk);
      report(!(scl === 1'b1 && bus_free === 1'b1 && busy === 1'b0 && cmd_ready === 1'b1), "R1",
             $sformatf("after reset scl/free/busy/ready=%b%b%b%b expected 1101", scl, bus_free, busy, cmd_ready));

      // R10: bit and STOP while bus free are ignored
      scramble();
      run_cmd(2'd1);
      run_cmd(2'd3);
      // minimum corner: all zero fields, no prescaling, no filter (R2, R4)
      set_set(1'b0, 0, 0, 0, 0, 0, 0, 0, 0); set_set(1'b1, 0, 0, 0, 0, 0, 0, 0, 0);
      hold = '0; filt = '0; hs_sel = 1'b0;
      run_cmd(2'd0);
      set_set(1'b0, 0, 0, 0, 0, 0, 0, 0, 0); hold = '0; filt = '0; hs_sel = 1'b0;
      run_cmd(2'd1);
      run_cmd(2'd0);                     // R10: START while held is ignored
      // R8: distinct fast and high-speed sets; long low so low-hold-1 wins over setup (R3)
      set_set(1'b0, 2, 3, 4, 1, 2, 6, 1, 5);
      set_set(1'b1, 5, 1, 2, 2, 12, 3, 2, 1);
      hold = 32'hFFFF_FF02; filt = 3'd7; hs_sel = 1'b1;
      run_cmd(2'd1);
      set_set(1'b0, 2, 3, 4, 1, 2, 6, 1, 5);
      set_set(1'b1, 5, 1, 2, 2, 12, 3, 2, 1);
      hold = 32'h0000_0002; filt = 3'd3; hs_sel = 1'b0;
      run_cmd(2'd2);                     // R7 with fast set
      // large prescaler corner (R2)
      set_set(1'b0, 30, 30, 30, 30, 30, 30, 20, 30); hold = 32'd30; filt = 3'd1; hs_sel = 1'b0;
      run_cmd(2'd1);
      set_set(1'b1, 9, 9, 9, 1, 20, 9, 20, 9); hold = 32'd5; filt = 3'd0; hs_sel = 1'b1;
      run_cmd(2'd3);                     // R6
      run_cmd(2'd2);                     // R10: repeated START while free is ignored

      // constrained random sequences
      for (int i = 0; i < 160; i++) begin
         int r;
         mx_f = (i % 4 == 0) ? 15 : 7;
         mx_d = (i % 5 == 0) ? 4 : 2;
         scramble();
         r = $urandom_range(99, 0);
         if (exp_free) run_cmd((r < 85) ? 2'd0 : 2'($urandom_range(3, 1)));
         else if (r < 55) run_cmd(2'd1);
         else if (r < 72) run_cmd(2'd2);
         else if (r < 92) run_cmd(2'd3);
         else             run_cmd(2'd0);
      end
      if (!exp_free) begin scramble(); run_cmd(2'd3); end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule